// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs one analog-to-digital conversion on its own once software has issued a single command write. The write carries two command bits and an input channel number. When both command bits are set in the same write and no conversion is in progress, the block selects the requested channel and steps through three phases in a fixed order. First comes a settling delay, which lets the analog network recover from the channel change. Next comes a tracking interval, during which the track-and-hold stage follows its input. Last comes the conversion itself.

At the end of tracking the block switches the track-and-hold control to hold and emits a one-cycle convert command. It then waits for the converter to report completion. On completion it latches the converter result and raises a new-data flag, which software can poll or use as an interrupt source. Reading the data register clears that flag. Two busy flags show the progress of the sequence. The settling flag covers the settle and track phases. The conversion flag covers the whole sequence from start to completion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A synchronous reset returns the block to idle: conversion not busy, settling not busy, track mode selected (`hold` = 0), no convert command, new-data flag low, data register 0, channel 0.
- R2: A sequence starts only on a write with `wr_en` = 1 in which bit 0 (start settling) and bit 1 (enable conversion) of `wr_data` are both 1. A write that sets only one of these bits has no effect on any output.
- R3: On an accepted start, `chan_sel` takes the value of `wr_data[CH_W+1:2]` in the next cycle. In that same cycle `settle_busy` and `conv_busy` both rise, and the settling phase then lasts SETTLE_CYC cycles (at least 1).
- R4: A tracking phase of TRACK_CYC cycles (at least 1) follows settling. `hold` stays 0 through both phases. `settle_busy` stays high for exactly SETTLE_CYC + TRACK_CYC cycles and falls when tracking ends.
- R5: In the cycle right after tracking, `hold` goes to 1 and `conv_cmd` is high for exactly one cycle, with `settle_busy` low.
- R6: After the command cycle the block waits for `adc_done`. The input is ignored in the command cycle and while idle. A sampled `adc_done` latches `adc_result` into `rd_data`, clears `conv_busy`, returns `hold` to 0 and sets `data_ready` in the next cycle.
- R7: A start write that arrives while `conv_busy` is high is ignored. It does not restart the sequence, it does not change its timing, and it leaves `chan_sel` unchanged.
- R8: `rd_en` clears `data_ready` in the next cycle while `rd_data` keeps its value. If completion and `rd_en` fall in the same cycle, `data_ready` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | CH_W+2 | Bit 0 start settling, bit 1 enable conversion, bits CH_W+1:2 channel |
| rd_en | input | 1 | Data register read strobe, clears new-data flag |
| adc_done | input | 1 | Converter reports the conversion finished |
| adc_result | input | DATA_W | Converter output word |
| chan_sel | output | CH_W | Selected input channel |
| hold | output | 1 | Track-and-hold control, 1 = hold, 0 = track |
| conv_cmd | output | 1 | One-cycle convert command |
| settle_busy | output | 1 | High during the settle and track phases |
| conv_busy | output | 1 | High from start until completion |
| data_ready | output | 1 | New result available |
| rd_data | output | DATA_W | Latched conversion result |

## Verification
The hardest cases to reach from the ports are those where several events land on a single clock edge. One is a completion pulse that arrives during the convert-command cycle, which must be ignored. Another is a read strobe that coincides with completion, where the new-data flag must stay set. A third is a start write that lands inside settling, tracking or the wait for completion. The stimulus finds the command cycle by watching `settle_busy` fall at the falling clock edge. It then places `adc_done`, `rd_en` and extra start writes on exact cycle offsets from that point. A behavioural model that counts elapsed phase cycles is compared against every output on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETTLE = 3'd1,
    SQ_TRACK  = 3'd2,
    SQ_CMD    = 3'd3,
    SQ_WAIT   = 3'd4
  } sq_state_t;

  localparam int unsigned CMD_SETTLE_BIT = 0;
  localparam int unsigned CMD_CONV_BIT   = 1;
  localparam int unsigned CH_LSB         = 2;

  // both handshake bits must be present in one write
  function automatic logic start_bits_ok(input logic settle_bit, input logic conv_bit);
    return settle_bit & conv_bit;
  endfunction

  // counter width able to hold the larger phase length minus one
  function automatic int unsigned phase_cnt_w(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > 2) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W       = 4,
  parameter int unsigned SETTLE_CYC = 5,
  parameter int unsigned TRACK_CYC  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W+1:0] wr_data,
  input  logic            adc_done,
  output logic [CH_W-1:0] chan_sel,
  output logic            hold,
  output logic            conv_cmd,
  output logic            settle_busy,
  output logic            conv_busy,
  output logic            conv_fin
);

  localparam int unsigned CNT_W = phase_cnt_w(SETTLE_CYC, TRACK_CYC);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TRACK_LOAD  = CNT_W'(TRACK_CYC - 1);

  sq_state_t        state, state_nx;
  logic             start_req, start_accept;
  logic             settle_end, track_end;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  // named internal events
  assign start_req    = wr_en && start_bits_ok(wr_data[CMD_SETTLE_BIT], wr_data[CMD_CONV_BIT]);
  assign start_accept = start_req && (state == SQ_IDLE);
  assign settle_end   = (state == SQ_SETTLE) && tmr_expired;
  assign track_end    = (state == SQ_TRACK) && tmr_expired;
  assign conv_fin     = (state == SQ_WAIT) && adc_done;

  assign tmr_load = start_accept || settle_end;
  assign tmr_val  = start_accept ? SETTLE_LOAD : TRACK_LOAD;

  adc_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE:   if (start_accept) state_nx = SQ_SETTLE;
      SQ_SETTLE: if (settle_end)   state_nx = SQ_TRACK;
      SQ_TRACK:  if (track_end)    state_nx = SQ_CMD;
      SQ_CMD:                      state_nx = SQ_WAIT;
      SQ_WAIT:   if (conv_fin)     state_nx = SQ_IDLE;
      default:                     state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      chan_sel <= '0;
    end else begin
      state <= state_nx;
      if (start_accept)
        chan_sel <= wr_data[CH_LSB +: CH_W];
    end
  end

  assign settle_busy = (state == SQ_SETTLE) || (state == SQ_TRACK);
  assign conv_busy   = (state != SQ_IDLE);
  assign hold        = (state == SQ_CMD) || (state == SQ_WAIT);
  assign conv_cmd    = (state == SQ_CMD);

  // R3
  start_flags_chk: assert property (@(posedge clk) disable iff (rst)
    start_accept |=> settle_busy && conv_busy && !hold);

  // R4
  settle_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    settle_busy |-> conv_busy && !hold && !conv_cmd);

  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_cmd |=> !conv_cmd && hold && conv_busy);

  // R5
  cmd_after_track_chk: assert property (@(posedge clk) disable iff (rst)
    track_end |=> conv_cmd && !settle_busy);

  // R6
  wait_done_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !conv_cmd && !adc_done) |=> conv_busy && hold);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && start_req) |=> !$rose(settle_busy) && $stable(chan_sel));

endmodule

// File: rtl/adc_seq_datareg.sv
module adc_seq_datareg #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_fin,
  input  logic [DATA_W-1:0] adc_result,
  input  logic              rd_en,
  output logic              data_ready,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (conv_fin) begin
        rd_data    <= adc_result;
        data_ready <= 1'b1;
      end else if (rd_en) begin
        data_ready <= 1'b0;
      end
    end
  end

  // R6
  ready_on_fin_chk: assert property (@(posedge clk) disable iff (rst)
    conv_fin |=> data_ready && (rd_data == $past(adc_result)));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !conv_fin) |=> !data_ready && $stable(rd_data));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned SETTLE_CYC = 5,
  parameter int unsigned TRACK_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W+1:0]   wr_data,
  input  logic              rd_en,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_result,
  output logic [CH_W-1:0]   chan_sel,
  output logic              hold,
  output logic              conv_cmd,
  output logic              settle_busy,
  output logic              conv_busy,
  output logic              data_ready,
  output logic [DATA_W-1:0] rd_data
);

  logic conv_fin;

  adc_seq_fsm #(
    .CH_W       (CH_W),
    .SETTLE_CYC (SETTLE_CYC),
    .TRACK_CYC  (TRACK_CYC)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .adc_done    (adc_done),
    .chan_sel    (chan_sel),
    .hold        (hold),
    .conv_cmd    (conv_cmd),
    .settle_busy (settle_busy),
    .conv_busy   (conv_busy),
    .conv_fin    (conv_fin)
  );

  adc_seq_datareg #(.DATA_W(DATA_W)) i_datareg (
    .clk        (clk),
    .rst        (rst),
    .conv_fin   (conv_fin),
    .adc_result (adc_result),
    .rd_en      (rd_en),
    .data_ready (data_ready),
    .rd_data    (rd_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !conv_busy && !settle_busy && !hold && !conv_cmd && !data_ready);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int CH_W   = 4;
  localparam int S_CYC  = 5;
  localparam int T_CYC  = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en;
  logic [CH_W+1:0]   wr_data;
  logic              rd_en;
  logic              adc_done;
  logic [DATA_W-1:0] adc_result;
  logic [CH_W-1:0]   chan_sel;
  logic              hold, conv_cmd, settle_busy, conv_busy, data_ready;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .CH_W(CH_W), .SETTLE_CYC(S_CYC), .TRACK_CYC(T_CYC)
  ) i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .adc_done(adc_done), .adc_result(adc_result), .chan_sel(chan_sel),
    .hold(hold), .conv_cmd(conv_cmd), .settle_busy(settle_busy),
    .conv_busy(conv_busy), .data_ready(data_ready), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase number plus elapsed-cycle count
  int m_phase = 0;  // 0 idle, 1 settle, 2 track, 3 command, 4 wait
  int m_elap = 0;
  int m_chan = 0;
  int m_ready = 0;
  int m_data = 0;
  bit m_valid = 0;

  always @(posedge clk) begin
    bit fin;
    cyc++;
    m_valid = 1;
    if (rst) begin
      m_phase = 0; m_elap = 0; m_chan = 0; m_ready = 0; m_data = 0;
    end else begin
      fin = (m_phase == 4) && adc_done;
      if (fin) begin
        m_data = adc_result;
        m_ready = 1;
      end else if (rd_en) m_ready = 0;
      case (m_phase)
        0: if (wr_en && wr_data[0] && wr_data[1]) begin
             m_phase = 1; m_elap = 0; m_chan = wr_data[CH_W+1:2];
           end
        1: begin m_elap++; if (m_elap == S_CYC) begin m_phase = 2; m_elap = 0; end end
        2: begin m_elap++; if (m_elap == T_CYC) m_phase = 3; end
        3: m_phase = 4;
        4: if (fin) m_phase = 0;
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      chk("R4 settle_busy model", settle_busy, (m_phase == 1 || m_phase == 2));
      chk("R6 conv_busy model", conv_busy, (m_phase != 0));
      chk("R4 hold model", hold, (m_phase == 3 || m_phase == 4));
      chk("R5 conv_cmd model", conv_cmd, (m_phase == 3));
      chk("R8 data_ready model", data_ready, m_ready);
      chk("R6 rd_data model", rd_data, m_data);
      chk("R3 chan_sel model", chan_sel, m_chan);
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic start_write(input int bits, input int ch);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {CH_W'(ch), 2'(bits)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one full sequence; busy_ch >= 0 injects a start write during settling
  task automatic run_seq(input int ch, input int res, input int delay,
                         input bit early_done, input bit rd_same, input int busy_ch);
    int n;
    start_write(3, ch);
    chk("R3 conv_busy after start", conv_busy, 1);
    chk("R3 settle_busy after start", settle_busy, 1);
    chk("R3 channel taken", chan_sel, ch);
    n = 0;
    while (settle_busy && n < 1000) begin
      n++;
      wr_en = (busy_ch >= 0) && (n == 2 || n == S_CYC + 1);
      wr_data = {CH_W'(busy_ch < 0 ? 0 : busy_ch), 2'b11};
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R4 settle_busy length", n, S_CYC + T_CYC);
    chk("R5 conv_cmd in first hold cycle", conv_cmd, 1);
    chk("R5 hold in command cycle", hold, 1);
    chk("R7 channel kept under busy write", chan_sel, ch);
    adc_result = DATA_W'(res);
    adc_done = early_done;
    @(negedge clk);
    adc_done = 1'b0;
    chk("R6 still waiting after command", conv_busy, 1);
    chk("R5 conv_cmd single cycle", conv_cmd, 0);
    if (busy_ch >= 0) begin
      wr_en = 1'b1; wr_data = {CH_W'(busy_ch), 2'b11};
    end
    repeat (delay) @(negedge clk);
    wr_en = 1'b0;
    adc_done = 1'b1;
    rd_en = rd_same;
    @(negedge clk);
    adc_done = 1'b0;
    rd_en = 1'b0;
    adc_result = '0;
    chk("R6 conv_busy cleared", conv_busy, 0);
    chk("R6 hold back to track", hold, 0);
    chk("R6 result latched", rd_data, res);
    chk("R8 data_ready set on completion", data_ready, 1);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    adc_done = 1'b0; adc_result = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset conv_busy", conv_busy, 0);
    chk("R1 reset settle_busy", settle_busy, 0);
    chk("R1 reset hold", hold, 0);
    chk("R1 reset conv_cmd", conv_cmd, 0);
    chk("R1 reset data_ready", data_ready, 0);
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset chan_sel", chan_sel, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: single handshake bits do nothing
    start_write(1, 3);
    repeat (2) @(negedge clk);
    chk("R2 settle bit alone", conv_busy, 0);
    chk("R2 settle bit alone channel", chan_sel, 0);
    start_write(2, 4);
    repeat (2) @(negedge clk);
    chk("R2 conv bit alone", conv_busy, 0);
    chk("R2 conv bit alone settle", settle_busy, 0);

    // R6: done while idle is ignored
    adc_done = 1'b1; adc_result = 12'h111;
    @(negedge clk);
    adc_done = 1'b0;
    @(negedge clk);
    chk("R6 idle done ignored", data_ready, 0);

    run_seq(5, 12'hABC, 4, 1'b0, 1'b0, -1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8 read clears data_ready", data_ready, 0);
    chk("R8 rd_data kept after read", rd_data, 12'hABC);

    // R6 early done in command cycle, R7 start writes while busy
    run_seq(9, 12'h5A3, 2, 1'b1, 1'b0, 2);
    chk("R7 channel after busy writes", chan_sel, 9);

    // R8 read coincides with completion
    run_seq(15, 12'hFFF, 0, 1'b0, 1'b1, -1);
    @(negedge clk);
    chk("R8 ready held on coincident read", data_ready, 1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8 cleared by later read", data_ready, 0);

    // R1 reset in the middle of a sequence
    start_write(3, 6);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset conv_busy", conv_busy, 0);
    chk("R1 mid reset chan", chan_sel, 0);
    chk("R1 mid reset hold", hold, 0);

    run_seq(1, 12'h042, 1, 1'b0, 1'b0, -1);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule